// File: doc/BRIEF.md
# Serially Configured Upper-Address Decoder

This block sits beside a bus peripheral and lets the peripheral's memory window be placed anywhere in host memory space rather than only in the lowest megabyte. It watches the four latchable upper address lines of an ISA-style bus. It holds them in a latch that follows the address-latch-enable strobe. It drives the peripheral's active-low chip select whenever the held lines equal a compare value.

The compare value is not written in parallel. The host reaches it through the peripheral, which raises a dedicated select line and clocks bits in over a serial clock and data pair. The most significant bit comes first. The shifted value takes effect when the select line falls, and only if a full word was shifted. A constant presence output lets the host find out that the decoder is fitted before it tries to configure it. All inputs are sampled on the system clock. The serial clock is recognised by its rising edge as seen in that clock domain.

Top module: `upper_addr_decoder`

## Requirements
- R1: After reset no compare value is loaded and `cs_n` stays high for every address, including address 0.
- R2: A 4-bit value shifted in MSB first, one bit per rising `cfg_clk` while `cfg_sel` is high, becomes the compare value when `cfg_sel` falls; `cs_n` then goes low exactly when the latched lines equal it.
- R3: While `bale` is high the latch is transparent, so `cs_n` follows `la` within the same cycle.
- R4: While `bale` is low the latch holds the lines present at the last clock with `bale` high; changes on `la` have no effect on `cs_n`.
- R5: Rising edges on `cfg_clk` while `cfg_sel` is low are ignored and leave the compare value unchanged.
- R6: A select window with fewer than 4 serial bits is discarded; the previous compare value (or the unloaded state) remains.
- R7: A select window with more than 4 serial bits keeps the last 4 bits shifted.
- R8: `present` is always high, reporting that the decode logic is fitted.
- R9: While `cfg_sel` is high the compare value in use does not change; a new value replaces it only when the window closes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bale | input | 1 | Address-latch-enable strobe, latch open while high |
| la | input | ADDR_W | Latchable upper address lines (LA20 up to LA23) |
| cfg_sel | input | 1 | Serial configuration select, active high |
| cfg_clk | input | 1 | Serial configuration clock, rising edge shifts |
| cfg_dat | input | 1 | Serial configuration data, MSB first |
| cs_n | output | 1 | Active-low chip select to the peripheral |
| present | output | 1 | Constant high presence indication |

## Verification
The decode is exercised with a vector table of matching, near-miss and unrelated addresses. Some vectors have the strobe open and some have it closed. This separates a transparent latch from a held one and separates equality from partial matches. Serial loads are tried at the exact word length, short of it and beyond it. They are also tried with clock pulses while the select line is low. These cases show whether the bit counting and the window gating, as well as the MSB-first order, decide the compare value. A check in the middle of a reload shows that the old value stays in force until the window closes.

// File: rtl/upper_addr_decoder.sv
module upper_addr_decoder #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bale,
  input  logic [ADDR_W-1:0] la,
  input  logic              cfg_sel,
  input  logic              cfg_clk,
  input  logic              cfg_dat,
  output logic              cs_n,
  output logic              present
);
  localparam int CW = $clog2(ADDR_W + 1);

  logic [ADDR_W-1:0] hold_q, shift_q, cmp_q;
  logic [CW-1:0]     cnt_q;
  logic              sclk_q, sel_q, loaded;
  logic [ADDR_W-1:0] addr_eff;
  logic              sclk_rise, win_close, full;

  assign sclk_rise = cfg_sel & cfg_clk & ~sclk_q;
  assign win_close = sel_q & ~cfg_sel;
  assign full      = (cnt_q == CW'(ADDR_W));
  assign addr_eff  = bale ? la : hold_q;
  assign cs_n      = ~(loaded && (addr_eff == cmp_q));
  assign present   = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      shift_q <= '0;
      cmp_q   <= '0;
      cnt_q   <= '0;
      sclk_q  <= 1'b0;
      sel_q   <= 1'b0;
      loaded  <= 1'b0;
    end else begin
      sclk_q <= cfg_clk;
      sel_q  <= cfg_sel;
      if (bale) hold_q <= la;
      if (cfg_sel && !sel_q) cnt_q <= '0;
      else if (sclk_rise) begin
        shift_q <= {shift_q[ADDR_W-2:0], cfg_dat};
        if (!full) cnt_q <= cnt_q + 1'b1;
      end
      if (win_close && full) begin
        cmp_q  <= shift_q;
        loaded <= 1'b1;
      end
    end
  end
endmodule

module upper_addr_decoder_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bale,
  input logic [ADDR_W-1:0] la,
  input logic              cfg_sel,
  input logic              cs_n,
  input logic              loaded,
  input logic [ADDR_W-1:0] cmp_q,
  input logic [ADDR_W-1:0] hold_q,
  input logic [ADDR_W-1:0] shift_q
);
  p_unloaded_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> cs_n);
  p_select_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (loaded && ((bale ? la : hold_q) == cmp_q)));
  p_transparent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && bale && la != cmp_q) |-> cs_n);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bale |=> $stable(hold_q));
  p_serial_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sel |=> $stable(shift_q));
  p_cmp_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel |=> $stable(cmp_q));
endmodule

bind upper_addr_decoder upper_addr_decoder_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .bale(bale), .la(la), .cfg_sel(cfg_sel),
  .cs_n(cs_n), .loaded(loaded), .cmp_q(cmp_q), .hold_q(hold_q),
  .shift_q(shift_q)
);

// File: tb/test_upper_addr_decoder.sv
module test_upper_addr_decoder;
  logic clk = 0, rst_n = 0, bale = 0, cfg_sel = 0, cfg_clk = 0, cfg_dat = 0;
  logic [3:0] la = '0;
  logic cs_n, present;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  upper_addr_decoder i_upper_addr_decoder (.*);

  // {bale, la, expected cs_n}; compare value loaded = 4'hA
  localparam logic [5:0] VEC [10] = '{
    {1'b1, 4'hA, 1'b0}, {1'b1, 4'hB, 1'b1}, {1'b1, 4'h2, 1'b1},
    {1'b1, 4'h8, 1'b1}, {1'b1, 4'hA, 1'b0}, {1'b0, 4'h3, 1'b0},
    {1'b0, 4'hF, 1'b0}, {1'b1, 4'h5, 1'b1}, {1'b0, 4'hA, 1'b1},
    {1'b0, 4'h0, 1'b1}};

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic d);
    cfg_dat = d; wait_clk(2);
    cfg_clk = 1; wait_clk(2);
    cfg_clk = 0; wait_clk(2);
  endtask

  task automatic load(logic [7:0] bits, int n);
    cfg_sel = 1; wait_clk(2);
    for (int i = n - 1; i >= 0; i--) pulse(bits[i]);
    cfg_sel = 0; wait_clk(3);
  endtask

  task automatic probe(string tag, logic [3:0] a, logic exp);
    bale = 1; la = a; #1;
    chk(tag, cs_n, exp);
    wait_clk(1);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(3); rst_n = 1; wait_clk(1);
    probe("R1 reset addr0", 4'h0, 1'b1);
    probe("R1 reset addrF", 4'hF, 1'b1);
    chk("R8 present", present, 1'b1);
    load(8'h05, 3);
    probe("R6 short from reset", 4'h5, 1'b1);
    probe("R6 short addr0", 4'h0, 1'b1);
    load(8'h0A, 4);
    for (int i = 0; i < 10; i++) begin
      bale = VEC[i][5]; la = VEC[i][4:1]; #1;
      chk($sformatf("R2/R3/R4 vec%0d", i), cs_n, VEC[i][0]);
      wait_clk(1);
    end
    probe("R2 match A", 4'hA, 1'b0);
    cfg_sel = 0;
    pulse(1'b0); pulse(1'b1); pulse(1'b1); pulse(1'b1);
    wait_clk(2);
    probe("R5 idle clocks keep A", 4'hA, 1'b0);
    probe("R5 no 7", 4'h7, 1'b1);
    load(8'h03, 2);
    probe("R6 short keeps A", 4'hA, 1'b0);
    probe("R6 short no 3", 4'h3, 1'b1);
    load(8'h35, 6);
    probe("R7 last four 5", 4'h5, 1'b0);
    probe("R7 not D", 4'hD, 1'b1);
    cfg_sel = 1; wait_clk(2);
    pulse(1'b0); pulse(1'b0); pulse(1'b1); pulse(1'b1);
    probe("R9 old value mid window", 4'h5, 1'b0);
    probe("R9 new value not yet", 4'h3, 1'b1);
    cfg_sel = 0; wait_clk(3);
    probe("R9 new value active", 4'h3, 1'b0);
    probe("R9 old value gone", 4'h5, 1'b1);
    probe("R3 strobe open", 4'h3, 1'b0);
    bale = 0; la = 4'h9; #1;
    chk("R4 held after strobe", cs_n, 1'b0);
    wait_clk(1);
    chk("R8 present end", present, 1'b1);
    rst_n = 0; wait_clk(2); rst_n = 1; wait_clk(1);
    probe("R1 after second reset", 4'h3, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule